// File: doc/BRIEF.md
# Paged Serial Flash Read Engine

This block is the device-side read path of a serial flash whose storage is split into pages of 264 bytes. It watches the chip-select, serial clock and serial data input of an SPI link. It oversamples them with the system clock, decodes a read command and collects the address and the don't-care bits. It then shifts array bytes out on the serial data output. Two read kinds exist. The continuous read keeps stepping through the whole array, so one transfer can stream every byte. The page read stays inside the page it was started in.

A page does not hold a power-of-two number of bytes, so the engine keeps the position as separate page and byte counters. The byte counter wraps at the end of a page by itself. The storage is a register array inside the block, and it is filled through a simple load port. Each time chip select falls, the engine records the idle level of the serial clock. It reads correctly from either idle level. Two opcodes exist for each read kind, and both behave the same way.

Top module: `paged_flash_reader`

## Requirements
- R1: After reset, `spi_miso_oe` is 0, `spi_miso` is 0 and `sck_idle_hi` is 0.
- R2: Opcodes 8'h68 and 8'hE8 start a continuous read, and 8'h52 and 8'hD2 start a page read. Any other opcode leaves `spi_miso_oe` at 0 until chip select rises.
- R3: A command has 8 opcode bits, then 24 address bits, then 32 don't-care bits, all taken MSB first. The address bits are 3 reserved bits, then a 12-bit page field, then a 9-bit byte field. The page used is the page field modulo PAGES. The first data bit is driven at the SCK falling edge that follows the 64th rising edge, and `spi_miso_oe` stays 0 before that edge.
- R4: Input bits are taken on SCK rising edges. Output bits change on SCK falling edges. Each byte is sent MSB first.
- R5: In a continuous read the byte position advances after each byte. After byte 263 it goes to byte 0 of the next page, and after the last page it goes to page 0.
- R6: In a page read, the byte after byte 263 is byte 0 of the same page.
- R7: A byte field of 264 or more starts the read at byte 0 of the selected page.
- R8: While chip select is high, `spi_miso_oe` is 0. A rise of chip select ends any transfer, and the next fall of chip select expects a new opcode.
- R9: On each fall of chip select, the SCK level is latched and shown on `sck_idle_hi`. Reads give the same data whether SCK idles low or high.
- R10: When `ld_en` is 1, the load port writes `ld_data` into the array at index page*264 + byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the SPI pins |
| rst | input | 1 | Synchronous reset, active high |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso; 0 means high impedance |
| sck_idle_hi | output | 1 | SCK level latched at the last chip-select fall |
| ld_en | input | 1 | Array load strobe |
| ld_addr | input | $clog2(PAGES*PAGE_BYTES) | Array load index |
| ld_data | input | 8 | Array load byte |

## Verification
The assertions assume that each SCK level, and each chip-select level, lasts longer than the three-cycle path from pin to output register. They also assume that the load port is idle while chip select is low. The bench holds each SCK phase for six system clocks and changes chip select only while SCK sits at its idle level. It loads the whole array before the first transfer. Random transfers pick the opcode, page, byte, length and idle level. Directed cases cover the page-end and array-end wraps, an out-of-range byte field, a bad opcode and an abort in the middle of a byte.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
  localparam int OPC_BITS   = 8;
  localparam int ADDR_BITS  = 24;
  localparam int PAGE_FLD   = 12;
  localparam int BYTE_FLD   = 9;
  localparam int KEEP_BITS  = PAGE_FLD + BYTE_FLD;
  localparam int DUMMY_BITS = 32;

  localparam logic [7:0] OP_CONT_LEGACY = 8'h68;
  localparam logic [7:0] OP_CONT_SPI    = 8'hE8;
  localparam logic [7:0] OP_PAGE_LEGACY = 8'h52;
  localparam logic [7:0] OP_PAGE_SPI    = 8'hD2;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_SKIP
  } rd_state_e;
endpackage

// File: rtl/pflash_pins.sv
module pflash_pins (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic cs_act,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s,
  output logic idle_hi
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] meta_q, sync_q;
  logic            sck_d, cs_d;
  logic            cs_fall;

  // two-stage synchronizer for every pin: {cs_n, sck, mosi}
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 3'b100;
      sync_q <= 3'b100;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      meta_q <= {cs_n, sck, mosi};
      sync_q <= meta_q;
      sck_d  <= sync_q[1];
      cs_d   <= sync_q[2];
    end
  end

  assign cs_act   = !sync_q[2];
  assign cs_fall  = cs_d && !sync_q[2];
  assign sck_rise = sync_q[1] && !sck_d;
  assign sck_fall = !sync_q[1] && sck_d;
  assign mosi_s   = sync_q[0];

  always_ff @(posedge clk) begin
    if (rst)          idle_hi <= 1'b0;
    else if (cs_fall) idle_hi <= sync_q[1];
  end

  // R9: idle level follows the clock level seen at the select fall
  p_mode_latch_r9: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> (idle_hi == $past(sync_q[1])));
endmodule

// File: rtl/pflash_array.sv
module pflash_array #(
  parameter int DEPTH = 1056,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pflash_seq.sv
module pflash_seq
  import pflash_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 264,
  localparam int PG_W   = $clog2(PAGES),
  localparam int BYTE_W = $clog2(PAGE_BYTES),
  localparam int IDX_W  = $clog2(PAGES*PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_act,
  input  logic             sck_rise,
  input  logic             sck_fall,
  input  logic             mosi_s,
  input  logic [7:0]       rdata,
  output logic [IDX_W-1:0] rd_idx,
  output logic             miso,
  output logic             miso_oe
);
  rd_state_e           st_q;
  logic [5:0]          cnt_q;
  logic [KEEP_BITS-1:0] sr_q;
  logic                cont_q;
  logic [PG_W-1:0]     page_q;
  logic [BYTE_W-1:0]   byte_q;
  logic [2:0]          bitpos_q;
  logic [6:0]          shr_q;

  logic [7:0]           opc_w;
  logic [KEEP_BITS-1:0] addr_w;
  logic [PAGE_FLD-1:0]  pfld_w;
  logic [BYTE_FLD-1:0]  bfld_w;
  logic                 adv;
  logic                 byte_last;

  assign opc_w  = {sr_q[6:0], mosi_s};
  assign addr_w = {sr_q[KEEP_BITS-2:0], mosi_s};
  assign pfld_w = addr_w[KEEP_BITS-1:BYTE_FLD];
  assign bfld_w = addr_w[BYTE_FLD-1:0];

  assign adv       = cs_act && sck_fall && (st_q == ST_DATA) && (bitpos_q == 3'd0);
  assign byte_last = (byte_q == BYTE_W'(PAGE_BYTES-1));
  assign rd_idx    = IDX_W'(page_q) * IDX_W'(PAGE_BYTES) + IDX_W'(byte_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_OPC;
      cnt_q    <= '0;
      sr_q     <= '0;
      cont_q   <= 1'b0;
      page_q   <= '0;
      byte_q   <= '0;
      bitpos_q <= '0;
      shr_q    <= '0;
      miso     <= 1'b0;
      miso_oe  <= 1'b0;
    end else if (!cs_act) begin
      st_q     <= ST_OPC;
      cnt_q    <= '0;
      bitpos_q <= '0;
      miso_oe  <= 1'b0;
    end else begin
      if (sck_rise) begin
        sr_q <= addr_w;
        unique case (st_q)
          ST_OPC: begin
            cnt_q <= cnt_q + 6'd1;
            if (cnt_q == 6'(OPC_BITS-1)) begin
              cnt_q <= '0;
              if (opc_w == OP_CONT_LEGACY || opc_w == OP_CONT_SPI) begin
                cont_q <= 1'b1;
                st_q   <= ST_ADDR;
              end else if (opc_w == OP_PAGE_LEGACY || opc_w == OP_PAGE_SPI) begin
                cont_q <= 1'b0;
                st_q   <= ST_ADDR;
              end else begin
                st_q   <= ST_SKIP;
              end
            end
          end
          ST_ADDR: begin
            cnt_q <= cnt_q + 6'd1;
            if (cnt_q == 6'(ADDR_BITS-1)) begin
              cnt_q  <= '0;
              page_q <= PG_W'(pfld_w % PAGE_FLD'(PAGES));
              byte_q <= (int'(bfld_w) >= PAGE_BYTES) ? '0 : BYTE_W'(bfld_w);
              st_q   <= ST_DUMMY;
            end
          end
          ST_DUMMY: begin
            cnt_q <= cnt_q + 6'd1;
            if (cnt_q == 6'(DUMMY_BITS-1)) begin
              cnt_q    <= '0;
              bitpos_q <= '0;
              st_q     <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
      if (sck_fall && st_q == ST_DATA) begin
        miso_oe  <= 1'b1;
        bitpos_q <= bitpos_q + 3'd1;
        if (bitpos_q == 3'd0) begin
          miso  <= rdata[7];
          shr_q <= rdata[6:0];
          if (byte_last) begin
            byte_q <= '0;
            if (cont_q) page_q <= page_q + PG_W'(1);
          end else begin
            byte_q <= byte_q + BYTE_W'(1);
          end
        end else begin
          miso  <= shr_q[6];
          shr_q <= {shr_q[5:0], 1'b0};
        end
      end
    end
  end

  // R8: output released whenever select is inactive
  p_hiz_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !miso_oe);
  // R3: driver only enabled in the data phase
  p_oe_in_data_r3: assert property (@(posedge clk) disable iff (rst)
    miso_oe |-> (st_q == ST_DATA));
  // R5: byte position never leaves the page
  p_byte_range_r5: assert property (@(posedge clk) disable iff (rst)
    int'(byte_q) < PAGE_BYTES);
  // R5: last byte of a page is followed by byte 0
  p_byte_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (adv && byte_last) |=> (byte_q == '0));
  // R6: a page read never changes page while streaming
  p_page_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DATA && !cont_q) |=> $stable(page_q));
endmodule

// File: rtl/paged_flash_reader.sv
module paged_flash_reader #(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 264,
  localparam int DEPTH = PAGES * PAGE_BYTES,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spi_cs_n,
  input  logic             spi_sck,
  input  logic             spi_mosi,
  output logic             spi_miso,
  output logic             spi_miso_oe,
  output logic             sck_idle_hi,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_addr,
  input  logic [7:0]       ld_data
);
  logic             cs_act, sck_rise, sck_fall, mosi_s;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       rdata;

  pflash_pins u_pins (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (spi_cs_n),
    .sck      (spi_sck),
    .mosi     (spi_mosi),
    .cs_act   (cs_act),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_s   (mosi_s),
    .idle_hi  (sck_idle_hi)
  );

  pflash_array #(.DEPTH(DEPTH)) u_array (
    .clk   (clk),
    .we    (ld_en),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (rd_idx),
    .rdata (rdata)
  );

  pflash_seq #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .cs_act   (cs_act),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_s   (mosi_s),
    .rdata    (rdata),
    .rd_idx   (rd_idx),
    .miso     (spi_miso),
    .miso_oe  (spi_miso_oe)
  );

  // R10: load port only used between transfers
  p_load_idle_r10: assert property (@(posedge clk) disable iff (rst)
    ld_en |-> !cs_act);
endmodule

// File: tb/paged_flash_reader_tb.sv
module paged_flash_reader_tb;
  localparam int PAGES = 4;
  localparam int PB    = 264;
  localparam int DEPTH = PAGES * PB;
  localparam int IW    = $clog2(DEPTH);
  localparam int H     = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_oe, idle_hi;
  logic ld_en = 1'b0;
  logic [IW-1:0] ld_addr = '0;
  logic [7:0] ld_data = '0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  paged_flash_reader #(.PAGES(PAGES), .PAGE_BYTES(PB)) u_dut (
    .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .sck_idle_hi(idle_hi),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  function automatic logic [7:0] pat(int idx);
    return 8'((idx * 37) ^ (idx >> 4) ^ 8'h5A);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [63:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sck = 1'b0; mosi = v[i]; wclk(H);
      sck = 1'b1; wclk(H);
    end
  endtask

  // R4: sample each bit at the end of the low phase after a falling edge
  task automatic read_byte(output logic [7:0] v, output bit oe_ok);
    oe_ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sck = 1'b0; wclk(H);
      v = {v[6:0], miso};
      if (!miso_oe) oe_ok = 1'b0;
      sck = 1'b1; wclk(H);
    end
  endtask

  task automatic select(bit idle);
    sck = idle; wclk(4);
    cs_n = 1'b0; wclk(6);
    check(idle_hi == idle, "R9 idle latch", idle_hi, idle);
  endtask

  task automatic deselect(bit idle);
    sck = idle; wclk(4);
    cs_n = 1'b1; wclk(6);
    check(!miso_oe, "R8 oe low after deselect", miso_oe, 0);
  endtask

  task automatic run_tx(logic [7:0] op, logic [11:0] pf, logic [8:0] bf,
                        int n, bit idle, int extra_bits);
    bit cont;
    int pg, by;
    logic [7:0] v;
    bit oe_ok;
    cont = (op == 8'h68 || op == 8'hE8);
    pg   = int'(pf) % PAGES;
    by   = (int'(bf) >= PB) ? 0 : int'(bf);   // R7
    select(idle);
    send_bits({56'd0, op}, 8);
    send_bits({40'd0, 3'b000, pf, bf}, 24);
    send_bits({32'd0, $urandom()}, 32);
    check(!miso_oe, "R3 oe low before data", miso_oe, 0);
    for (int k = 0; k < n; k++) begin
      read_byte(v, oe_ok);
      check(v == pat(pg * PB + by), cont ? "R5 continuous byte" : "R6 page byte",
            v, pat(pg * PB + by));
      check(oe_ok, "R3 oe high in data", oe_ok, 1);
      by++;
      if (by == PB) begin
        by = 0;
        if (cont) pg = (pg + 1) % PAGES;
      end
    end
    for (int k = 0; k < extra_bits; k++) begin
      sck = 1'b0; wclk(H); sck = 1'b1; wclk(H);
    end
    deselect(idle);
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [7:0] ops [4];
    void'($urandom(32'h1234_5EED));
    ops[0] = 8'h68; ops[1] = 8'hE8; ops[2] = 8'h52; ops[3] = 8'hD2;
    wclk(4);
    rst = 1'b0;
    wclk(2);
    // R1
    check(!miso_oe, "R1 reset oe", miso_oe, 0);
    check(!miso, "R1 reset miso", miso, 0);
    check(!idle_hi, "R1 reset idle", idle_hi, 0);

    // R10: fill the array through the load port
    for (int i = 0; i < DEPTH; i++) begin
      ld_en = 1'b1; ld_addr = IW'(i); ld_data = pat(i);
      wclk(1);
    end
    ld_en = 1'b0;
    wclk(4);

    // R10 / R3: start of array, both idle levels
    run_tx(8'h68, 12'd0, 9'd0, 3, 1'b0, 0);
    run_tx(8'hE8, 12'd0, 9'd5, 3, 1'b1, 0);
    // R5: page crossing and last page back to page 0
    run_tx(8'h68, 12'd1, 9'd261, 5, 1'b0, 0);
    run_tx(8'hE8, 12'd3, 9'd262, 5, 1'b1, 0);
    // R6: page read wraps within the page
    run_tx(8'h52, 12'd1, 9'd261, 6, 1'b0, 0);
    run_tx(8'hD2, 12'd3, 9'd263, 3, 1'b1, 0);
    // R7: byte field out of range
    run_tx(8'h52, 12'd2, 9'd300, 2, 1'b0, 0);
    // R3: page field above PAGES folds modulo PAGES
    run_tx(8'h68, 12'd6, 9'd10, 2, 1'b1, 0);

    // R2: unknown opcode never drives the output
    begin
      bit quiet;
      quiet = 1'b1;
      select(1'b0);
      send_bits({56'd0, 8'h0B}, 8);
      send_bits({$urandom(), $urandom()}, 56);
      for (int i = 0; i < 16; i++) begin
        sck = 1'b0; wclk(H);
        if (miso_oe) quiet = 1'b0;
        sck = 1'b1; wclk(H);
      end
      check(quiet, "R2 bad opcode stays quiet", quiet, 1);
      deselect(1'b0);
    end

    // R8: abort in mid-byte, then a fresh command decodes
    run_tx(8'h68, 12'd2, 9'd100, 1, 1'b0, 3);
    run_tx(8'hD2, 12'd2, 9'd40, 2, 1'b0, 0);

    // random transfers
    for (int t = 0; t < 8; t++) begin
      logic [7:0] op;
      logic [8:0] bf;
      op = ops[$urandom_range(0, 3)];
      bf = ($urandom_range(0, 3) == 0) ? 9'($urandom_range(255, 263))
                                       : 9'($urandom_range(0, 263));
      run_tx(op, 12'($urandom_range(0, 4095)), bf,
             int'($urandom_range(1, 14)), 1'($urandom_range(0, 1)), 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule